// File: doc/BRIEF.md
# Filtered Receive Message FIFO Controller

This block runs the index bookkeeping for a ring of message buffers that acts as a receive FIFO inside a message-oriented serial controller. The protocol engine reports each finished reception with one pulse. The pulse carries three facts about the message: whether it had an error, whether it hit one of the dedicated receive identifiers, and whether it passed the programmable FIFO acceptance filter. The block accepts an error-free message that hits no dedicated identifier but passes the filter. For that message it raises a store strobe in the same cycle and presents the slot number that the payload storage must write.

Software sets the ring depth at run time as a highest slot number from 0 to 15. The ring always starts at slot 0. After reading the oldest slot, the CPU unlocks it with a single-cycle pulse. The put and get indices are internal to the block. A separate full flag tells a completely filled ring apart from an empty one when the two indices are equal. A sticky overrun flag records a good message that arrived while the ring was full. The block drives an interrupt request from the non-empty and overrun conditions, each gated by its own enable.

Top module: `rx_msg_fifo`

## Requirements
- R1: The ring covers slots 0 through `cfgLastSlot` (0 to 15). A store never presents a `wrSlot` above `cfgLastSlot`.
- R2: `storeEn` is high in a cycle exactly when `msgDone`=1, `idHit`=0, `filterHit`=1, `msgErr`=0, the ring is not full and `cfgLastSlot` is unchanged. In all other cases nothing is stored.
- R3: Successive stores after reset or after a depth change go to slots 0, 1, 2 and so on. The put index advances by one after each store.
- R4: After a store into slot `cfgLastSlot`, the next store goes to slot 0.
- R5: An `unlockPulse` advances the get index by one, with the same wrap rule, only while `notEmpty` is 1. An unlock on an empty ring has no effect. A store and an unlock may both take effect in the same cycle.
- R6: The ring becomes full when a store makes the put index equal the get index. While full, no message is stored. Any effective unlock clears the full state.
- R7: `overrunFlag` is set, from the next cycle, by an accepted error-free message that finds the ring full. An errored message never sets it. A one-cycle `ovrClear` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: `notEmpty` is 1 whenever the put and get indices differ, or the ring is full.
- R9: `irq` = (`ieNotEmpty` AND `notEmpty`) OR (`ieOverrun` AND `overrunFlag`).
- R10: A change of `cfgLastSlot` returns both indices to 0 and clears the full state on the next clock edge. No store happens in the cycle the change is first seen.
- R11: After reset, `notEmpty`, `overrunFlag` and `irq` are 0, and the first store goes to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLastSlot | input | IDX_W | Highest slot of the ring |
| msgDone | input | 1 | End-of-reception pulse |
| msgErr | input | 1 | Reception finished with an error |
| idHit | input | 1 | Message matched a dedicated receive identifier |
| filterHit | input | 1 | Message passed the FIFO acceptance filter |
| unlockPulse | input | 1 | CPU releases the oldest slot |
| ovrClear | input | 1 | Write-one-to-clear pulse for the overrun flag |
| ieNotEmpty | input | 1 | Interrupt enable for non-empty |
| ieOverrun | input | 1 | Interrupt enable for overrun |
| storeEn | output | 1 | Write the current message into `wrSlot` |
| wrSlot | output | IDX_W | Slot addressed by the put index |
| notEmpty | output | 1 | Ring holds at least one message |
| overrunFlag | output | 1 | Sticky overrun status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default of 16 slots. This lets it program the smallest ring (a single slot, where one store already fills it) and the largest ring (16 slots, where the put index runs through every value before wrapping). A three-slot ring is used for the full/overrun, unlock-on-empty and simultaneous store-and-unlock cases. Depth changes while the ring is partly filled are also exercised.

// File: rtl/rx_msg_fifo_pkg.sv
package rx_msg_fifo_pkg;
  // strobes from control to index datapath
  typedef struct packed {
    logic advPut;
    logic advGet;
    logic clrIdx;
  } fifoStrobe_t;
endpackage

// File: rtl/rx_msg_fifo_datapath.sv
module rx_msg_fifo_datapath
  import rx_msg_fifo_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [IDX_W-1:0] lastSlot,
  output logic [IDX_W-1:0] putIdx,
  output logic [IDX_W-1:0] getIdx,
  output logic             putNextEqGet
);
  logic [IDX_W-1:0] putNext;
  logic [IDX_W-1:0] getNext;

  function automatic logic [IDX_W-1:0] wrapInc(input logic [IDX_W-1:0] idx,
                                               input logic [IDX_W-1:0] last);
    return (idx >= last) ? '0 : idx + 1'b1;
  endfunction

  assign putNext      = wrapInc(putIdx, lastSlot);
  assign getNext      = wrapInc(getIdx, lastSlot);
  assign putNextEqGet = (putNext == getIdx);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrIdx) begin
      putIdx <= '0;
      getIdx <= '0;
    end else begin
      if (strobe.advPut) putIdx <= putNext;
      if (strobe.advGet) getIdx <= getNext;
    end
  end
endmodule

// File: rtl/rx_msg_fifo_control.sv
module rx_msg_fifo_control
  import rx_msg_fifo_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] cfgLastSlot,
  input  logic             msgDone,
  input  logic             msgErr,
  input  logic             idHit,
  input  logic             filterHit,
  input  logic             unlockPulse,
  input  logic             ovrClear,
  input  logic             ieNotEmpty,
  input  logic             ieOverrun,
  input  logic [IDX_W-1:0] putIdx,
  input  logic [IDX_W-1:0] getIdx,
  input  logic             putNextEqGet,
  output fifoStrobe_t      strobe,
  output logic [IDX_W-1:0] lastSlot,
  output logic             storeEn,
  output logic             notEmpty,
  output logic             fullFlag,
  output logic             overrunFlag,
  output logic             irq
);
  logic cfgChg;
  logic goodMsg;
  logic unlockOk;

  assign cfgChg   = (cfgLastSlot != lastSlot);
  assign goodMsg  = msgDone & ~idHit & filterHit & ~msgErr;
  assign notEmpty = (putIdx != getIdx) | fullFlag;
  assign storeEn  = goodMsg & ~fullFlag & ~cfgChg;
  assign unlockOk = unlockPulse & notEmpty & ~cfgChg;
  assign irq      = (ieNotEmpty & notEmpty) | (ieOverrun & overrunFlag);

  always_comb begin
    strobe        = '0;
    strobe.advPut = storeEn;
    strobe.advGet = unlockOk;
    strobe.clrIdx = cfgChg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSlot    <= '1;
      fullFlag    <= 1'b0;
      overrunFlag <= 1'b0;
    end else begin
      lastSlot <= cfgLastSlot;
      if (cfgChg || unlockOk)           fullFlag <= 1'b0;
      else if (storeEn && putNextEqGet) fullFlag <= 1'b1;
      if (goodMsg && fullFlag && !cfgChg) overrunFlag <= 1'b1;
      else if (ovrClear)                  overrunFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
  import rx_msg_fifo_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(NUM_SLOTS)-1:0] cfgLastSlot,
  input  logic                         msgDone,
  input  logic                         msgErr,
  input  logic                         idHit,
  input  logic                         filterHit,
  input  logic                         unlockPulse,
  input  logic                         ovrClear,
  input  logic                         ieNotEmpty,
  input  logic                         ieOverrun,
  output logic                         storeEn,
  output logic [$clog2(NUM_SLOTS)-1:0] wrSlot,
  output logic                         notEmpty,
  output logic                         overrunFlag,
  output logic                         irq
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  fifoStrobe_t      strobe;
  logic [IDX_W-1:0] putIdx;
  logic [IDX_W-1:0] getIdx;
  logic [IDX_W-1:0] lastSlot;
  logic             putNextEqGet;
  logic             fullFlag;

  rx_msg_fifo_control #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLastSlot(cfgLastSlot),
    .msgDone(msgDone), .msgErr(msgErr), .idHit(idHit), .filterHit(filterHit),
    .unlockPulse(unlockPulse), .ovrClear(ovrClear),
    .ieNotEmpty(ieNotEmpty), .ieOverrun(ieOverrun),
    .putIdx(putIdx), .getIdx(getIdx), .putNextEqGet(putNextEqGet),
    .strobe(strobe), .lastSlot(lastSlot), .storeEn(storeEn),
    .notEmpty(notEmpty), .fullFlag(fullFlag), .overrunFlag(overrunFlag), .irq(irq)
  );

  rx_msg_fifo_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lastSlot(lastSlot),
    .putIdx(putIdx), .getIdx(getIdx), .putNextEqGet(putNextEqGet)
  );

  assign wrSlot = putIdx;
endmodule

// File: rtl/rx_msg_fifo_checker.sv
module rx_msg_fifo_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [IDX_W-1:0] cfgLastSlot,
  input logic             msgDone,
  input logic             msgErr,
  input logic             idHit,
  input logic             filterHit,
  input logic             unlockPulse,
  input logic             ieNotEmpty,
  input logic             ieOverrun,
  input logic             storeEn,
  input logic [IDX_W-1:0] wrSlot,
  input logic             overrunFlag,
  input logic             irq,
  input logic             notEmpty,
  input logic             fullFlag,
  input logic [IDX_W-1:0] getIdx,
  input logic [IDX_W-1:0] lastSlot
);
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    storeEn |-> wrSlot <= cfgLastSlot);

  p_store_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    storeEn |-> (msgDone && !idHit && filterHit && !msgErr));

  p_get_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!unlockPulse && cfgLastSlot == lastSlot) |=> $stable(getIdx));

  p_no_store_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> !storeEn);

  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $past(msgDone && filterHit && !idHit && !msgErr && fullFlag));

  p_full_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> notEmpty);

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ieNotEmpty && !ieOverrun) |-> !irq);
endmodule

bind rx_msg_fifo rx_msg_fifo_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgLastSlot(cfgLastSlot), .msgDone(msgDone),
  .msgErr(msgErr), .idHit(idHit), .filterHit(filterHit), .unlockPulse(unlockPulse),
  .ieNotEmpty(ieNotEmpty), .ieOverrun(ieOverrun), .storeEn(storeEn), .wrSlot(wrSlot),
  .overrunFlag(overrunFlag), .irq(irq), .notEmpty(notEmpty), .fullFlag(fullFlag),
  .getIdx(getIdx), .lastSlot(lastSlot)
);

// File: tb/rx_msg_fifo_test.sv
module rx_msg_fifo_test;
  localparam int NUM_SLOTS = 16;
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IDX_W-1:0] cfgLastSlot = 4'd2;
  logic msgDone = 0, msgErr = 0, idHit = 0, filterHit = 0;
  logic unlockPulse = 0, ovrClear = 0, ieNotEmpty = 0, ieOverrun = 0;
  logic storeEn, notEmpty, overrunFlag, irq;
  logic [IDX_W-1:0] wrSlot;

  always #5 clk = ~clk;

  rx_msg_fifo #(.NUM_SLOTS(NUM_SLOTS)) uut (.*);

  int nChecks = 0, nFails = 0;
  int expQ[$];
  int mPut = 0, mGet = 0, mLast = 2;
  bit mFull = 0, mOvr = 0;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wrapNext(int idx);
    return (idx >= mLast) ? 0 : idx + 1;
  endfunction

  // monitor: compares every store against the scoreboard queue (R2, R3, R4)
  always @(negedge clk) begin
    #2;
    if (rstN && storeEn) begin
      if (expQ.size() == 0) check("R2 unexpected store", 1, 0);
      else check("R3/R4 store slot", int'(wrSlot), expQ.pop_front());
    end
  end

  task automatic step(bit d, bit e, bit h, bit f, bit u, bit c);
    bit good, storeOk, unlOk;
    @(negedge clk);
    msgDone = d; msgErr = e; idHit = h; filterHit = f; unlockPulse = u; ovrClear = c;
    good    = d && !h && f && !e;
    storeOk = good && !mFull;
    unlOk   = u && (mPut != mGet || mFull);
    if (storeOk) expQ.push_back(mPut);
    if (unlOk) mFull = 0;
    else if (storeOk && wrapNext(mPut) == mGet) mFull = 1;
    if (good && !storeOk) mOvr = 1;
    else if (c) mOvr = 0;
    if (storeOk) mPut = wrapNext(mPut);
    if (unlOk) mGet = wrapNext(mGet);
    @(negedge clk);
    msgDone = 0; msgErr = 0; idHit = 0; filterHit = 0; unlockPulse = 0; ovrClear = 0;
  endtask

  task automatic checkStatus(string req);
    bit ne;
    #3;
    ne = (mPut != mGet) || mFull;
    check({req, " notEmpty"}, notEmpty, ne);
    check({req, " overrun"}, overrunFlag, mOvr);
    check({req, " irq"}, irq, (ieNotEmpty && ne) || (ieOverrun && mOvr));
  endtask

  task automatic setLast(int n);
    @(negedge clk);
    cfgLastSlot = n[IDX_W-1:0];
    @(negedge clk);
    mPut = 0; mGet = 0; mFull = 0; mLast = n;
  endtask

  task automatic good(); step(1, 0, 0, 1, 0, 0); endtask
  task automatic unlock(); step(0, 0, 0, 0, 1, 0); endtask

  initial begin
    #2_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    checkStatus("R11");
    check("R11 no store", storeEn, 0);

    // R2 rejected messages: identifier hit, filter miss, errored
    step(1, 0, 1, 1, 0, 0); checkStatus("R2 idHit");
    step(1, 0, 0, 0, 0, 0); checkStatus("R2 filter miss");
    step(1, 1, 0, 1, 0, 0); checkStatus("R2 errored");

    // R3/R6 fill three-slot ring
    good(); checkStatus("R3");
    good(); good(); checkStatus("R6 full");
    step(1, 1, 0, 1, 0, 0); checkStatus("R7 errored while full");
    ieOverrun = 1;
    good(); checkStatus("R7 overrun set");
    step(1, 0, 0, 1, 0, 1); checkStatus("R7 set beats clear");
    step(0, 0, 0, 0, 0, 1); checkStatus("R7 cleared");

    // R5 drain, then unlock on empty ignored
    ieNotEmpty = 1;
    unlock(); checkStatus("R5 unlock from full");
    unlock(); unlock(); checkStatus("R5 drained");
    unlock(); checkStatus("R5 unlock empty ignored");
    good(); checkStatus("R4 wrapped store");
    // R5 simultaneous store and unlock
    step(1, 0, 0, 1, 1, 0); checkStatus("R5 store+unlock");
    good(); good(); checkStatus("R6 full again");
    step(1, 0, 0, 1, 1, 0); checkStatus("R6 store blocked unlock taken");

    // R10 depth change resets indices
    setLast(15); checkStatus("R10 depth change");
    for (int i = 0; i < 17; i++) good();
    checkStatus("R4 sixteen slots full");
    for (int i = 0; i < 3; i++) unlock();
    for (int i = 0; i < 3; i++) good();
    checkStatus("R4 wrap at 15");
    step(0, 0, 0, 0, 0, 1);

    // R1 single-slot ring
    setLast(0); checkStatus("R1 depth one");
    good(); checkStatus("R1 one slot full");
    good(); checkStatus("R1 overrun depth one");
    ieNotEmpty = 0; ieOverrun = 0;
    checkStatus("R9 masked");
    unlock(); good(); checkStatus("R1 reuse slot 0");

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule